// File: doc/BRIEF.md
# Console Keyboard Receiver Register Interface

This block is the processor-facing register pair for a console keyboard receiver. The deserializer outside the block delivers either a received character, as a one-cycle strobe with an 8-bit code, or a break indication on a separate one-cycle strobe. The block keeps a 16-bit data buffer that holds the character and its error flags. It also keeps a status/control register with a "character waiting" flag and an interrupt-enable flag, and it drives a level interrupt request.

The processor reaches the two registers through a simple single-cycle port. A one-bit address selects the register, and read and write strobes act in the cycle they are asserted. Read data is combinational from the current register contents. The side effects of a read or write take hold at the next clock edge. When a break arrives and the halt-enable input is high, the block emits a one-cycle halt request. A mode input chooses 7-bit or 8-bit character storage.

Top module: `conrx_regif`

## Requirements
- R1: Reading the status register (address 0) returns the waiting flag in bit 7, the interrupt enable in bit 6 and zero in every other bit. A write to address 0 changes only the enable, taken from bit 6 of the write data. Writes to address 1 have no effect.
- R2: A character strobe stores the code in buffer bits 7:0 with bits 15:8 zero, unless R5 applies, and sets the waiting flag.
- R3: With `seven_bit_mode` high, the stored character keeps only its low 7 bits and bit 7 is stored as 0. With the mode low, all 8 bits are kept.
- R4: Reading the buffer (address 1) returns all 16 bits. At the following edge it clears the waiting flag and bits 15:8 of the stored buffer, and keeps bits 7:0.
- R5: A character arriving while the waiting flag is set, with no buffer read in the same cycle, replaces the character and sets bit 15 (error summary) and bit 14 (overrun).
- R6: A break strobe loads the buffer with 0xA400 and sets the waiting flag. This value has error summary in bit 15, framing error in bit 13, received break in bit 10, and a zero character. A break in the same cycle as a character takes precedence.
- R7: `halt_req` is high for exactly the one cycle after the edge at which a break strobe is sampled with `halt_en` high. Otherwise it is low.
- R8: `irq` rises after a character or break arrives while the enable is set. It also rises after a status write with bit 6 set while a character is waiting. It falls after a status write with bit 6 clear, or after a buffer read.
- R9: Reset clears the buffer, both status flags, `irq` and `halt_req`.
- R10: When a character arrives in the same cycle as a buffer read, the read returns the old contents and the new character is stored without overrun bits. The waiting flag stays set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| char_stb | input | 1 | One-cycle strobe: a character has been received |
| char_code | input | 8 | Received character code |
| brk_stb | input | 1 | One-cycle strobe: a break has been detected |
| seven_bit_mode | input | 1 | 1 = store 7-bit characters, 0 = store 8 bits |
| halt_en | input | 1 | Permits a break to request a processor halt |
| reg_addr | input | 1 | Register select: 0 status, 1 buffer |
| rd_en | input | 1 | Register read strobe |
| wr_en | input | 1 | Register write strobe |
| wr_data | input | 16 | Write data |
| rd_data | output | 16 | Read data, zero when no read is active |
| irq | output | 1 | Interrupt request level |
| halt_req | output | 1 | One-cycle halt request |

## Verification
The bench builds the block with its default parameters: a 16-bit register width and an 8-bit character. These are the sizes at which the fixed break pattern 0xA400 and the status bit positions 7 and 6 have their stated meaning. With these values, the bench can reach the following by direct stimulus:
- the overrun path, where a second character arrives before a read;
- the read/arrival collision of R10;
- both character modes applied to a code with bit 7 set;
- the enable being set while a character is already waiting.

// File: rtl/conrx_pkg.sv
package conrx_pkg;

    localparam int REG_W  = 16;
    localparam int CHAR_W = 8;

    // status register bit positions
    localparam int WAIT_BIT = 7;
    localparam int IEN_BIT  = 6;

    // register addresses
    localparam logic ADDR_CSR = 1'b0;
    localparam logic ADDR_BUF = 1'b1;

    typedef struct packed {
        logic done;
        logic ie;
        logic irq;
        logic halt;
    } ctl_state_t;

endpackage

// File: rtl/conrx_capture.sv
module conrx_capture
    import conrx_pkg::*;
#(
    parameter int RW = REG_W,
    parameter int CW = CHAR_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          char_stb,
    input  logic [CW-1:0] char_code,
    input  logic          brk_stb,
    input  logic          seven_bit_mode,
    input  logic          done_q,
    input  logic          buf_rd,
    output logic [RW-1:0] buf_q
);

    localparam int ERR_POS = RW - 1;
    localparam int OVR_POS = RW - 2;
    localparam int FRM_POS = RW - 3;
    localparam int BRK_POS = RW - 6;
    localparam logic [CW-1:0] MASK7 = {1'b0, {(CW-1){1'b1}}};
    localparam logic [CW-1:0] MASK8 = {CW{1'b1}};

    logic [RW-1:0] buf_d;
    logic [CW-1:0] code_m;

    always_comb begin
        code_m = char_code & (seven_bit_mode ? MASK7 : MASK8);
        buf_d  = buf_q;
        if (buf_rd) begin
            buf_d[RW-1:CW] = '0;
        end
        if (brk_stb) begin
            buf_d          = '0;
            buf_d[ERR_POS] = 1'b1;
            buf_d[FRM_POS] = 1'b1;
            buf_d[BRK_POS] = 1'b1;
        end else if (char_stb) begin
            buf_d          = '0;
            buf_d[CW-1:0]  = code_m;
            if (done_q && !buf_rd) begin
                buf_d[ERR_POS] = 1'b1;
                buf_d[OVR_POS] = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) buf_q <= '0;
        else        buf_q <= buf_d;
    end

    // R6: break always leaves the fixed error pattern
    a_r6_break_pattern: assert property (@(posedge clk) disable iff (!rst_n)
        brk_stb |=> (buf_q[ERR_POS] && buf_q[FRM_POS] && buf_q[BRK_POS]
                     && buf_q[CW-1:0] == '0));

    // R5: arrival onto an unread character flags overrun
    a_r5_overrun: assert property (@(posedge clk) disable iff (!rst_n)
        (char_stb && !brk_stb && done_q && !buf_rd) |=> (buf_q[ERR_POS] && buf_q[OVR_POS]));

    // R4: read with no arrival keeps the character and drops the flags
    a_r4_keep_char: assert property (@(posedge clk) disable iff (!rst_n)
        (buf_rd && !char_stb && !brk_stb) |=> (buf_q[RW-1:CW] == '0
                                               && buf_q[CW-1:0] == $past(buf_q[CW-1:0])));

endmodule

// File: rtl/conrx_ctl.sv
module conrx_ctl
    import conrx_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic arrive,
    input  logic brk_stb,
    input  logic halt_en,
    input  logic buf_rd,
    input  logic csr_wr,
    input  logic wr_ie,
    output logic done_q,
    output logic ie_q,
    output logic irq_q,
    output logic halt_q
);

    ctl_state_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        st_d.halt = brk_stb && halt_en;
        if (csr_wr) begin
            st_d.ie = wr_ie;
            if (!wr_ie)         st_d.irq = 1'b0;
            else if (st_q.done) st_d.irq = 1'b1;
        end
        if (buf_rd) begin
            st_d.done = 1'b0;
            st_d.irq  = 1'b0;
        end
        if (arrive) begin
            st_d.done = 1'b1;
            if (st_d.ie) st_d.irq = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign done_q = st_q.done;
    assign ie_q   = st_q.ie;
    assign irq_q  = st_q.irq;
    assign halt_q = st_q.halt;

    // R8: request is asserted exactly when a character waits with enable set
    a_r8_irq_level: assert property (@(posedge clk) disable iff (!rst_n)
        irq_q == (done_q && ie_q));

    // R4: buffer read with no arrival clears the waiting flag
    a_r4_read_clears_done: assert property (@(posedge clk) disable iff (!rst_n)
        (buf_rd && !arrive) |=> !done_q);

    // R7: halt pulse follows an enabled break and nothing else
    a_r7_halt_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        (brk_stb && halt_en) |=> halt_q);
    a_r7_no_halt: assert property (@(posedge clk) disable iff (!rst_n)
        !(brk_stb && halt_en) |=> !halt_q);

    // R10: arrival wins over a same-cycle read
    a_r10_arrive_wins: assert property (@(posedge clk) disable iff (!rst_n)
        arrive |=> done_q);

endmodule

// File: rtl/conrx_regif.sv
module conrx_regif
    import conrx_pkg::*;
#(
    parameter int RW = REG_W,
    parameter int CW = CHAR_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          char_stb,
    input  logic [CW-1:0] char_code,
    input  logic          brk_stb,
    input  logic          seven_bit_mode,
    input  logic          halt_en,
    input  logic          reg_addr,
    input  logic          rd_en,
    input  logic          wr_en,
    input  logic [RW-1:0] wr_data,
    output logic [RW-1:0] rd_data,
    output logic          irq,
    output logic          halt_req
);

    logic          buf_rd, csr_wr, arrive;
    logic          done_q, ie_q;
    logic [RW-1:0] buf_q;
    logic [RW-1:0] csr_view;

    assign buf_rd = rd_en && (reg_addr == ADDR_BUF);
    assign csr_wr = wr_en && (reg_addr == ADDR_CSR);
    assign arrive = char_stb || brk_stb;

    conrx_capture #(.RW(RW), .CW(CW)) u_capture (
        .clk            (clk),
        .rst_n          (rst_n),
        .char_stb       (char_stb),
        .char_code      (char_code),
        .brk_stb        (brk_stb),
        .seven_bit_mode (seven_bit_mode),
        .done_q         (done_q),
        .buf_rd         (buf_rd),
        .buf_q          (buf_q)
    );

    conrx_ctl u_ctl (
        .clk     (clk),
        .rst_n   (rst_n),
        .arrive  (arrive),
        .brk_stb (brk_stb),
        .halt_en (halt_en),
        .buf_rd  (buf_rd),
        .csr_wr  (csr_wr),
        .wr_ie   (wr_data[IEN_BIT]),
        .done_q  (done_q),
        .ie_q    (ie_q),
        .irq_q   (irq),
        .halt_q  (halt_req)
    );

    always_comb begin
        csr_view           = '0;
        csr_view[WAIT_BIT] = done_q;
        csr_view[IEN_BIT]  = ie_q;
        rd_data            = '0;
        if (rd_en) rd_data = (reg_addr == ADDR_BUF) ? buf_q : csr_view;
    end

    // R1: status reads expose only the two implemented bits
    a_r1_csr_bits: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && reg_addr == ADDR_CSR) |->
            ((rd_data & ~((RW'(1) << WAIT_BIT) | (RW'(1) << IEN_BIT))) == '0));

    // R1: status write only moves the enable
    a_r1_write_ie: assert property (@(posedge clk) disable iff (!rst_n)
        (csr_wr && !arrive && !buf_rd) |=> (done_q == $past(done_q)));

endmodule

// File: tb/conrx_regif_bench.sv
module conrx_regif_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        char_stb = 1'b0;
    logic [7:0]  char_code = '0;
    logic        brk_stb = 1'b0;
    logic        seven_bit_mode = 1'b0;
    logic        halt_en = 1'b0;
    logic        reg_addr = 1'b0;
    logic        rd_en = 1'b0;
    logic        wr_en = 1'b0;
    logic [15:0] wr_data = '0;
    logic [15:0] rd_data;
    logic        irq;
    logic        halt_req;

    int checks = 0;
    int fails  = 0;
    bit ended  = 1'b0;

    logic [15:0] exp_q[$];
    string       tag_q[$];

    // reference model
    logic [15:0] m_buf = '0;
    logic        m_done = 1'b0;
    logic        m_ie = 1'b0;
    logic        m_halt = 1'b0;

    always #10 clk = ~clk;

    conrx_regif u_conrx_regif (
        .clk(clk), .rst_n(rst_n), .char_stb(char_stb), .char_code(char_code),
        .brk_stb(brk_stb), .seven_bit_mode(seven_bit_mode), .halt_en(halt_en),
        .reg_addr(reg_addr), .rd_en(rd_en), .wr_en(wr_en), .wr_data(wr_data),
        .rd_data(rd_data), .irq(irq), .halt_req(halt_req)
    );

    task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: got %h expected %h", tag, act, exp);
        end
    endtask

    // monitor: compares read data against the scoreboard queue
    initial forever begin
        @(negedge clk);
        #5;
        if (rd_en) begin
            if (exp_q.size() == 0) begin
                check("scoreboard", rd_data, 16'hxxxx);
            end else begin
                check(tag_q.pop_front(), rd_data, exp_q.pop_front());
            end
        end
    end

    // driver: one operation cycle, model updated from the requirements
    task automatic step(input string tag, input bit cs, input logic [7:0] code, input bit sev,
                        input bit bk, input bit hen, input bit rd, input bit wr,
                        input bit adr, input logic [15:0] wd);
        bit bufread;
        logic [7:0] c;
        @(negedge clk);
        char_stb = cs; char_code = code; seven_bit_mode = sev; brk_stb = bk;
        halt_en = hen; rd_en = rd; wr_en = wr; reg_addr = adr; wr_data = wd;
        bufread = rd && adr;
        if (rd) begin
            exp_q.push_back(adr ? m_buf : {8'h00, m_done, m_ie, 6'h00});
            tag_q.push_back(tag);
        end
        if (wr && !adr) m_ie = wd[6];
        if (bk) begin
            m_buf = 16'hA400;
        end else if (cs) begin
            c = sev ? (code & 8'h7F) : code;
            m_buf = (m_done && !bufread) ? {8'hC0, c} : {8'h00, c};
        end else if (bufread) begin
            m_buf = {8'h00, m_buf[7:0]};
        end
        if (bufread) m_done = 1'b0;
        if (cs || bk) m_done = 1'b1;
        m_halt = bk && hen;
        @(negedge clk);
        char_stb = 0; brk_stb = 0; rd_en = 0; wr_en = 0; wr_data = '0;
        #5;
        check({tag, " irq"}, {15'd0, irq}, {15'd0, m_done & m_ie});
        check({tag, " halt"}, {15'd0, halt_req}, {15'd0, m_halt});
        m_halt = 1'b0;
    endtask

    task automatic rd_csr(input string tag); step(tag, 0, 0, 0, 0, 0, 1, 0, 0, 0); endtask
    task automatic rd_buf(input string tag); step(tag, 0, 0, 0, 0, 0, 1, 0, 1, 0); endtask
    task automatic wr_csr(input string tag, input logic [15:0] d); step(tag, 0, 0, 0, 0, 0, 0, 1, 0, d); endtask
    task automatic put(input string tag, input logic [7:0] c, input bit sev); step(tag, 1, c, sev, 0, 0, 0, 0, 0, 0); endtask

    initial begin
        #2000000;
        if (!ended) begin
            ended = 1'b1;
            fails++; checks++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #5;
        check("R9 reset irq", {15'd0, irq}, 16'd0);
        check("R9 reset halt", {15'd0, halt_req}, 16'd0);
        rd_csr("R9 reset csr");
        rd_buf("R9 reset buf");

        wr_csr("R1 write all ones", 16'hFFFF);
        rd_csr("R1 only ie set");
        step("R1 buf write ignored", 0, 0, 0, 0, 0, 0, 1, 1, 16'hFFFF);
        rd_buf("R1 buf unchanged");

        put("R8 arrival with ie", 8'h41, 0);
        rd_csr("R1 done and ie");
        rd_buf("R2 R4 char read");
        rd_csr("R4 done cleared");

        put("R3 seven bit", 8'hC1, 1);
        rd_buf("R3 masked char");
        put("R3 eight bit", 8'hC1, 0);
        rd_buf("R3 full char");

        wr_csr("R8 ie off", 16'h0000);
        put("R8 arrival without ie", 8'h55, 0);
        wr_csr("R8 ie on while waiting", 16'h0040);
        wr_csr("R8 ie off drops", 16'h0000);
        rd_csr("R8 status after toggles");

        put("R5 overrun", 8'h66, 0);
        rd_buf("R5 overrun flags");
        rd_buf("R4 flags cleared char kept");

        wr_csr("R8 ie on", 16'h0040);
        step("R7 break halt", 0, 0, 0, 1, 1, 0, 0, 0, 0);
        rd_buf("R6 break pattern");
        rd_buf("R6 after read");
        step("R7 break no halt", 0, 0, 0, 1, 0, 0, 0, 0, 0);
        step("R6 break beats char", 1, 8'h77, 0, 1, 0, 0, 0, 0, 0);
        rd_buf("R6 break wins");

        put("R10 first", 8'h12, 0);
        step("R10 collide", 1, 8'h34, 0, 0, 0, 1, 0, 1, 0);
        rd_csr("R10 done kept");
        rd_buf("R10 new char no overrun");

        put("R9 before reset", 8'h5A, 0);
        @(negedge clk);
        rst_n = 1'b0;
        m_buf = '0; m_done = 0; m_ie = 0;
        #5;
        check("R9 reset irq drop", {15'd0, irq}, 16'd0);
        @(negedge clk);
        rst_n = 1'b1;
        rd_csr("R9 csr after reset");
        rd_buf("R9 buf after reset");

        repeat (2) @(negedge clk);
        if (!ended) begin
            ended = 1'b1;
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

endmodule